// File: doc/BRIEF.md
# Video Capture Acquisition Sequencer

This block decides when incoming video is written to memory. It watches the video horizontal and vertical syncs and runs a small state machine that opens a capture enable at a vertical sync. Software programs it through a byte-wide register port. The capture can run without end, stop after one whole frame, or stop after one chosen field of an interlaced source. When a single capture finishes, the block clears the start bit by itself, so software can poll that bit to learn that memory may be read.

The block also tracks which field is arriving. The field can come from an external field pin or from an internal detector. The internal detector measures the line length between horizontal syncs and checks where in the line the vertical sync begins. Either source can be inverted. At each vertical sync the block can raise an even-field request or an odd-field request. Each request stays pending until software clears it.

State machine: `ST_IDLE` (no capture) goes to `ST_ARMED` once start is set. `ST_ARMED` goes back to `ST_IDLE` if start is cleared. At a vertical sync it goes to `ST_CAP_A`, provided that any field condition is met. `ST_CAP_A` (first field captured) acts at the next vertical sync. It stays in `ST_CAP_A` when continuous. It goes to `ST_CAP_B` for the second field of an interlaced frame. It goes to `ST_IDLE` on a stop or on completion. `ST_CAP_B` (second field captured) returns to `ST_IDLE` at the next vertical sync.

Top module: `vcap_seq`

## Requirements
- R1: After reset, cap_active, field_odd, irq_even and irq_odd are 0. The mode register (address 0) reads 0x00. The status register (address 2) reads 0x00 while both syncs are inactive.
- R2: Writing mode bit 0 (start) to 1 does not change cap_active at once. cap_active goes to 1 in the cycle after the next vertical sync leading edge.
- R3: With mode bit 1 clear (continuous), capture stays active across vertical syncs. Clearing start takes effect only at the next vertical sync leading edge, where cap_active drops.
- R4: With mode bit 1 set, bit 2 clear and interlaced input, capture covers two fields. At the third vertical sync, cap_active drops and mode bit 0 clears itself.
- R5: With mode bits 1 and 2 set, capture waits for the field chosen by mode bit 3 (0 = even, 1 = odd). It covers that single field, then drops and clears mode bit 0.
- R6: Mode bit 6 set marks progressive input. The field reads even (0), a single capture ends after one field, and mode bit 2 is ignored.
- R7: Mode bits 4 and 5 make the video hsync and vsync inputs active high when set and active low when clear. Status bit 4 reads the live active hsync and bit 3 the live active vsync.
- R8: With the internal source, the field latched at a vertical sync leading edge is odd (1) when the edge falls at or past half of the measured line length, and even (0) otherwise.
- R9: Control bit 2 (address 1) selects the ext_field pin as the field source. Control bit 3 inverts the field.
- R10: At a vertical sync leading edge, an enabled even-field (control bit 0) or odd-field (control bit 1) request becomes pending and drives irq_even or irq_odd. It is readable in status bits 0 and 1 and is cleared only by writing 1 to the same bit at address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_hsync | input | 1 | Video horizontal sync, polarity set by mode bit 4 |
| vid_vsync | input | 1 | Video vertical sync, polarity set by mode bit 5 |
| ext_field | input | 1 | External field indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 control, 2 status / request clear |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| cap_active | output | 1 | Capture enable for the data path |
| field_odd | output | 1 | Current field, 1 = odd |
| irq_even | output | 1 | Pending even-field vertical sync request |
| irq_odd | output | 1 | Pending odd-field vertical sync request |

## Verification
The sync edge is seen at the first clock edge where the active level is present. cap_active, field_odd, the pending requests and the self-cleared start bit all change on that same edge, and register writes take effect on the edge that ends the strobe. The bench therefore drives on falling edges. It checks capture and field results only once a whole field has been driven, well after the vertical sync edge. It reads registers one time unit after setting the address. For the deferral checks, it samples a few cycles after a write and before the next vertical sync.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAP_A,
        ST_CAP_B
    } cap_state_e;

    // register addresses
    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // mode register bits
    localparam int M_START  = 0;
    localparam int M_SINGLE = 1;
    localparam int M_FIELD  = 2;
    localparam int M_ODD    = 3;
    localparam int M_HSPOL  = 4;
    localparam int M_VSPOL  = 5;
    localparam int M_PROG   = 6;

    // control register bits
    localparam int C_IRQ_EVEN = 0;
    localparam int C_IRQ_ODD  = 1;
    localparam int C_EXT      = 2;
    localparam int C_INV      = 3;
endpackage

// File: rtl/vcap_edge.sv
module vcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol_high,
    output logic lvl,
    output logic lead
);
    logic prev_q;

    assign lvl  = raw ~^ pol_high;
    assign lead = lvl & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end
endmodule

// File: rtl/vcap_field.sv
module vcap_field #(
    parameter int PIX_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_lead,
    input  logic vs_lead,
    input  logic progressive,
    input  logic ext_sel,
    input  logic invert,
    input  logic ext_field,
    output logic field_q,
    output logic field_nxt
);
    logic [PIX_W-1:0] pix_cnt;
    logic [PIX_W-1:0] line_len;
    logic             field_int;
    logic             field_src;

    always_comb begin
        field_int = (pix_cnt >= (line_len >> 1));
        field_src = ext_sel ? ext_field : field_int;
        field_nxt = progressive ? 1'b0 : (field_src ^ invert);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt  <= '0;
            line_len <= '0;
            field_q  <= 1'b0;
        end else begin
            if (hs_lead) begin
                pix_cnt  <= '0;
                line_len <= pix_cnt + 1'b1;
            end else if (pix_cnt != '1) begin
                pix_cnt <= pix_cnt + 1'b1;
            end
            if (vs_lead) field_q <= field_nxt;
        end
    end
endmodule

// File: rtl/vcap_fsm.sv
module vcap_fsm
    import vcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vs_lead,
    input  logic field_nxt,
    input  logic start,
    input  logic single,
    input  logic field_only,
    input  logic want_odd,
    input  logic progressive,
    output logic cap_active,
    output logic done
);
    cap_state_e state_q, state_d;
    logic       field_pick;
    logic       one_field;

    assign field_pick = single & field_only & ~progressive;
    assign one_field  = field_pick | progressive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!start)
                    state_d = ST_IDLE;
                else if (vs_lead && (!field_pick || (field_nxt == want_odd)))
                    state_d = ST_CAP_A;
            end
            ST_CAP_A: begin
                if (vs_lead) begin
                    if (!start)        state_d = ST_IDLE;
                    else if (!single)  state_d = ST_CAP_A;
                    else if (one_field) state_d = ST_IDLE;
                    else               state_d = ST_CAP_B;
                end
            end
            ST_CAP_B: begin
                if (vs_lead) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_active = (state_q == ST_CAP_A) || (state_q == ST_CAP_B);
        done = vs_lead && start && single &&
               (((state_q == ST_CAP_A) && one_field) || (state_q == ST_CAP_B));
    end
endmodule

// File: rtl/vcap_seq.sv
module vcap_seq
    import vcap_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vid_hsync,
    input  logic       vid_vsync,
    input  logic       ext_field,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cap_active,
    output logic       field_odd,
    output logic       irq_even,
    output logic       irq_odd
);
    localparam int NSYNC = 2;

    logic [7:0]       mode_q;
    logic [7:0]       ctrl_q;
    logic [1:0]       pend_q;
    logic [1:0]       pend_set;
    logic [1:0]       pend_ack;
    logic [NSYNC-1:0] sync_raw, sync_pol, sync_lvl, sync_lead;
    logic             hs_lead, vs_lead, field_nxt, done;

    assign sync_raw = {vid_vsync, vid_hsync};
    assign sync_pol = {mode_q[M_VSPOL], mode_q[M_HSPOL]};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        vcap_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (sync_raw[i]),
            .pol_high (sync_pol[i]),
            .lvl      (sync_lvl[i]),
            .lead     (sync_lead[i])
        );
    end

    assign hs_lead = sync_lead[0];
    assign vs_lead = sync_lead[1];

    vcap_field #(.PIX_W(PIX_W)) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_lead     (hs_lead),
        .vs_lead     (vs_lead),
        .progressive (mode_q[M_PROG]),
        .ext_sel     (ctrl_q[C_EXT]),
        .invert      (ctrl_q[C_INV]),
        .ext_field   (ext_field),
        .field_q     (field_odd),
        .field_nxt   (field_nxt)
    );

    vcap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .vs_lead     (vs_lead),
        .field_nxt   (field_nxt),
        .start       (mode_q[M_START]),
        .single      (mode_q[M_SINGLE]),
        .field_only  (mode_q[M_FIELD]),
        .want_odd    (mode_q[M_ODD]),
        .progressive (mode_q[M_PROG]),
        .cap_active  (cap_active),
        .done        (done)
    );

    assign pend_set[0] = vs_lead & ~field_nxt & ctrl_q[C_IRQ_EVEN];
    assign pend_set[1] = vs_lead &  field_nxt & ctrl_q[C_IRQ_ODD];
    assign pend_ack    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctrl_q <= '0;
            pend_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata;
            else if (done)                    mode_q[M_START] <= 1'b0;
            if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
            pend_q <= (pend_q & ~pend_ack) | pend_set;
        end
    end

    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = mode_q;
            A_CTRL:  reg_rdata = ctrl_q;
            A_STAT:  reg_rdata = {3'b000, sync_lvl[0], sync_lvl[1], field_odd, pend_q};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq_even = pend_q[0];
    assign irq_odd  = pend_q[1];
endmodule

// File: rtl/vcap_seq_chk.sv
module vcap_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic vs_lead,
    input logic cap_active,
    input logic field_odd,
    input logic irq_even,
    input logic irq_odd
);
    // R2: capture opens only at a vertical sync edge
    assert_cap_rise_on_vsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_active) |-> $past(vs_lead));

    // R3: capture closes only at a vertical sync edge
    assert_cap_fall_on_vsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_active) |-> $past(vs_lead));

    // R8: field indication holds between vertical syncs
    assert_field_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $past(vs_lead));

    // R10: a new odd request comes with an odd field
    assert_irq_odd_matches_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_odd) |-> field_odd);

    // R10: a new even request comes with an even field
    assert_irq_even_matches_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_even) |-> (!field_odd && $past(vs_lead)));
endmodule

bind vcap_seq vcap_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vs_lead    (vs_lead),
    .cap_active (cap_active),
    .field_odd  (field_odd),
    .irq_even   (irq_even),
    .irq_odd    (irq_odd)
);

// File: tb/vcap_seq_tb.sv
module vcap_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_hsync = 1'b1;
    logic       vid_vsync = 1'b1;
    logic       ext_field = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cap_active, field_odd, irq_even, irq_odd;

    logic hs_pol = 1'b0;
    logic vs_pol = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    logic [7:0] rv;

    localparam int LINE = 40;
    localparam int NVEC = 14;
    // {write, mode, odd position, exp cap, exp field, exp start}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h03, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h47, 1'b1, 1'b1, 1'b0, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h31, 1'b1, 1'b1, 1'b1, 1'b1},
        {1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    vcap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
        .ext_field(ext_field), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_active(cap_active),
        .field_odd(field_odd), .irq_even(irq_even), .irq_odd(irq_odd)
    );

    always #5 clk = ~clk;

    function automatic string row_req(input int i);
        case (i)
            0:       return "R2";
            1, 2:    return "R3";
            3, 4, 5: return "R4";
            6, 7, 8: return "R5";
            9, 10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) begin
            hs_pol = d[4]; vs_pol = d[5];
            vid_hsync = ~hs_pol; vid_vsync = ~vs_pol;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // three lines; vertical sync begins early (even) or late (odd) in the last line
    task automatic run_field(input logic odd_pos);
        int k;
        k = odd_pos ? 30 : 5;
        for (int ln = 0; ln < 3; ln++) begin
            for (int c = 0; c < LINE; c++) begin
                @(negedge clk);
                vid_hsync = (c < 4) ? hs_pol : ~hs_pol;
                vid_vsync = (ln == 2 && c >= k && c < k + 8) ? vs_pol : ~vs_pol;
            end
        end
        @(negedge clk);
        vid_hsync = ~hs_pol; vid_vsync = ~vs_pol;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                summary();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cap_active", {7'b0, cap_active}, 8'h00);
        chk("R1", "field_odd", {7'b0, field_odd}, 8'h00);
        chk("R1", "irqs", {6'b0, irq_odd, irq_even}, 8'h00);
        rd(2'd0, rv); chk("R1", "mode reg", rv, 8'h00);
        rd(2'd2, rv); chk("R1", "status reg", rv, 8'h00);

        // prime line length measurement
        run_field(1'b0);

        // table walk (R2..R7, R8 through field positions)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][12]) wr(2'd0, VEC[i][11:4]);
            run_field(VEC[i][3]);
            chk(row_req(i), $sformatf("row %0d cap", i), {7'b0, cap_active}, {7'b0, VEC[i][2]});
            chk(row_req(i), $sformatf("row %0d field R8", i), {7'b0, field_odd}, {7'b0, VEC[i][1]});
            rd(2'd0, rv);
            chk(row_req(i), $sformatf("row %0d start bit", i), {7'b0, rv[0]}, {7'b0, VEC[i][0]});
        end

        // R2 start deferred to vertical sync; R3 stop deferred
        wr(2'd0, 8'h31);
        repeat (5) @(negedge clk);
        chk("R2", "cap before vsync", {7'b0, cap_active}, 8'h00);
        run_field(1'b0);
        chk("R2", "cap after vsync", {7'b0, cap_active}, 8'h01);
        wr(2'd0, 8'h30);
        repeat (5) @(negedge clk);
        chk("R3", "cap held after stop write", {7'b0, cap_active}, 8'h01);
        run_field(1'b0);
        chk("R3", "cap after stop vsync", {7'b0, cap_active}, 8'h00);

        // R7 live sync status with active-high polarity
        @(negedge clk); vid_vsync = vs_pol;
        repeat (2) @(negedge clk);
        rd(2'd2, rv);
        chk("R7", "vsync live bit", {7'b0, rv[3]}, 8'h01);
        chk("R7", "hsync live bit", {7'b0, rv[4]}, 8'h00);
        @(negedge clk); vid_vsync = ~vs_pol;

        // R9 external field source and inversion
        wr(2'd1, 8'h04);
        ext_field = 1'b1;
        run_field(1'b0);
        chk("R9", "external field", {7'b0, field_odd}, 8'h01);
        wr(2'd1, 8'h0C);
        run_field(1'b0);
        chk("R9", "inverted external field", {7'b0, field_odd}, 8'h00);
        wr(2'd1, 8'h08);
        run_field(1'b0);
        chk("R9", "inverted internal field", {7'b0, field_odd}, 8'h01);
        ext_field = 1'b0;

        // R10 requests, pending, write-one-to-clear
        wr(2'd1, 8'h01);
        run_field(1'b0);
        chk("R10", "even request", {6'b0, irq_odd, irq_even}, 8'h01);
        run_field(1'b1);
        chk("R10", "even pending, odd masked", {6'b0, irq_odd, irq_even}, 8'h01);
        rd(2'd2, rv);
        chk("R10", "status pending bits", {6'b0, rv[1:0]}, 8'h01);
        wr(2'd2, 8'h02);
        chk("R10", "clear of other bit ignored", {6'b0, irq_odd, irq_even}, 8'h01);
        wr(2'd2, 8'h01);
        chk("R10", "even cleared", {6'b0, irq_odd, irq_even}, 8'h00);
        wr(2'd1, 8'h02);
        run_field(1'b1);
        chk("R10", "odd request", {6'b0, irq_odd, irq_even}, 8'h02);
        wr(2'd2, 8'h02);
        chk("R10", "odd cleared", {6'b0, irq_odd, irq_even}, 8'h00);

        summary();
    end
endmodule